// File: doc/BRIEF.md
# Infrared Carrier Generator with Envelope Timer

This block produces the transmit waveform for an infrared remote-control link. A carrier oscillator alternates between a high phase and a low phase. Each phase has its own programmable width, from 1 to 256 clocks. A 9-bit envelope timer counts down and gates the carrier. Loading a nonzero count starts a mark, and the carrier runs until the count reaches zero. No software toggling is needed inside a burst.

A controller programs the block through a single-cycle register write port. There are four targets: the low-phase width, the high-phase width together with a carrier-disable bit, the envelope timer, and a control word holding the output-enable flag. The envelope timer decrements once per pulse on `tick_en`, which is a prescaled timebase supplied from outside. The current timer value and an idle flag can be read at any time. A controller polls the idle flag before it loads the next mark or space.

When output is enabled, the REM output follows one of two sources. If the carrier is enabled, REM carries the gated carrier. If the carrier is disabled, REM carries the plain timer-running level. The LED output shows the timer-running level whenever output is enabled.

Top module: `ir_carrier_envelope`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both counters clear, the carrier-disable bit sets and the output-enable flag clears. After that edge `rem_out` and `led_out` are 0 and `tmr_idle` is 1.
- R2: With `wr_sel` = 0 the low-phase width is written from `wr_data[7:0]`. With `wr_sel` = 1 the high-phase width is written from `wr_data[7:0]`, and bit 9 of `wr_data` is written as the carrier-disable bit. A width field value v gives a phase of v+1 clocks, so 0 gives 1 clock and 255 gives 256 clocks.
- R3: Whenever gating begins, the carrier starts in its high phase. `rem_out` is 1 in the first cycle after the timer write that starts it.
- R4: A width write made during a phase does not change the length of that phase. The new width applies from the next phase boundary where that phase kind begins.
- R5: With `wr_sel` = 2 the timer loads `wr_data[8:0]`. It decrements by one at each clock edge where `tick_en` is 1 and it is nonzero. It holds its value when `tick_en` is 0. It stops at zero. `tmr_idle` is 1 exactly when the timer value is zero.
- R6: A timer write while the timer is running reloads it at once with the new value. Writing zero stops it.
- R7: With output enabled and the carrier enabled, `rem_out` is the carrier while the timer is nonzero, and 0 while it is zero.
- R8: With output enabled and the carrier disabled, `rem_out` is 1 while the timer is nonzero and 0 while it is zero.
- R9: With `wr_sel` = 3, `wr_data[0]` is written as the output-enable flag. While it is 0, `rem_out` and `led_out` stay 0 even with the timer running.
- R10: While output is enabled, `led_out` is 1 exactly when the timer is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Write target: 0 low width, 1 high width and disable, 2 timer, 3 control |
| wr_data | input | 10 | Write data |
| tick_en | input | 1 | Timebase pulse that decrements the envelope timer |
| rem_out | output | 1 | Transmit waveform |
| led_out | output | 1 | Transmission indicator |
| tmr_idle | output | 1 | High when the envelope timer is at zero |
| tmr_value | output | 9 | Current envelope timer value |

## Verification
The hardest situation to reach is a width write that lands in the middle of a running phase. It must stretch neither the current phase nor the phase after it, and the new width must show up only in the next phase of its own kind. The bench gets there by holding `tick_en` low, which freezes the timer so the carrier runs without expiring. It then issues the width write in a known cycle after the start and compares `rem_out` against a cycle-by-cycle pattern worked out from the old and new widths. The reload-while-running case is reached the same way, with `tick_en` held high and a second timer write issued two cycles into a countdown.

// File: rtl/ir_tx_pkg.sv
// Package: shared types for the infrared transmit block.
// Assumes a 2-bit write selector; the encodings are part of the register map.
package ir_tx_pkg;

    typedef enum logic [1:0] {
        SEL_LOW_W  = 2'd0,
        SEL_HIGH_W = 2'd1,
        SEL_TIMER  = 2'd2,
        SEL_CTRL   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic car_off;
        logic out_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{car_off: 1'b1, out_en: 1'b0};

endpackage

// File: rtl/ir_tx_regs.sv
// Module: ir_tx_regs
// Holds the two phase widths and the control flags, and turns a timer
// write into a load strobe. Assumes one-clock write strobes. The
// carrier-disable bit is the top bit of the write data word.
module ir_tx_regs
    import ir_tx_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int TMR_W   = 9,
    parameter int DATA_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [PHASE_W-1:0] lo_width,
    output logic [PHASE_W-1:0] hi_width,
    output ctrl_t              ctrl,
    output logic               tmr_load,
    output logic [TMR_W-1:0]   tmr_load_val
);

    localparam int DIS_BIT = DATA_W - 1;

    wr_sel_e sel;

    // Purpose: view the raw selector as the register-map enum.
    assign sel = wr_sel_e'(wr_sel);

    // Purpose: timer load strobe and value go straight to the timer.
    assign tmr_load     = wr_en && (sel == SEL_TIMER);
    assign tmr_load_val = wr_data[TMR_W-1:0];

    // Purpose: capture width and control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_width <= '0;
            hi_width <= '0;
            ctrl     <= CTRL_RESET;
        end else if (wr_en) begin
            case (sel)
                SEL_LOW_W:  lo_width <= wr_data[PHASE_W-1:0];
                SEL_HIGH_W: begin
                    hi_width     <= wr_data[PHASE_W-1:0];
                    ctrl.car_off <= wr_data[DIS_BIT];
                end
                SEL_CTRL:   ctrl.out_en <= wr_data[0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/ir_env_timer.sv
// Module: ir_env_timer
// Envelope down counter. A load takes priority over counting. The count
// decrements on each tick while it is nonzero and rests at zero. Assumes
// tick_en is a single-clock timebase pulse (or held high for full rate).
module ir_env_timer #(
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count,
    output logic             running
);

    // Purpose: load, decrement or hold the envelope count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick_en && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Purpose: running means the envelope is still open.
    assign running = (count != '0);

endmodule

// File: rtl/ir_carrier_gen.sv
// Module: ir_carrier_gen
// Carrier oscillator with separate high and low phase widths (value+1
// clocks each). The width of a phase is latched when that phase begins,
// so a width change never cuts a phase short. While not gated it parks in
// the high phase, so every burst starts high.
module ir_carrier_gen #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate,
    input  logic [PHASE_W-1:0] hi_width,
    input  logic [PHASE_W-1:0] lo_width,
    output logic               car_hi
);

    localparam int CNT_W = PHASE_W + 1;

    logic [CNT_W-1:0]   cnt;
    logic [PHASE_W-1:0] cur_len;
    logic               at_end;

    // Purpose: detect the last clock of the current phase.
    assign at_end = (cnt == {1'b0, cur_len});

    // Purpose: step the phase counter and flip phase at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_hi  <= 1'b1;
            cnt     <= '0;
            cur_len <= '0;
        end else if (!gate) begin
            car_hi  <= 1'b1;
            cnt     <= '0;
            cur_len <= hi_width;
        end else if (at_end) begin
            car_hi  <= !car_hi;
            cnt     <= '0;
            cur_len <= car_hi ? lo_width : hi_width;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ir_out_sel.sv
// Module: ir_out_sel
// Chooses what REM and LED show from the control flags, the envelope
// state and the carrier phase. Purely combinational; all inputs are
// register outputs, so the pins change only just after a clock edge.
module ir_out_sel (
    input  logic out_en,
    input  logic car_off,
    input  logic running,
    input  logic car_hi,
    output logic rem,
    output logic led
);

    // Purpose: gated carrier, plain level or quiet, per the flags.
    always_comb begin
        rem = 1'b0;
        led = 1'b0;
        if (out_en && running) begin
            led = 1'b1;
            rem = car_off ? 1'b1 : car_hi;
        end
    end

endmodule

// File: rtl/ir_carrier_envelope.sv
// Module: ir_carrier_envelope
// Top of the infrared transmit waveform generator: register file,
// envelope timer, carrier oscillator and output selection. Assumes a
// single clock, synchronous active-low reset, and an external prescaled
// tick for the envelope timer.
module ir_carrier_envelope
    import ir_tx_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int TMR_W   = 9,
    localparam int DATA_W = ((PHASE_W + 2) > TMR_W) ? (PHASE_W + 2) : TMR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_en,
    output logic              rem_out,
    output logic              led_out,
    output logic              tmr_idle,
    output logic [TMR_W-1:0]  tmr_value
);

    logic [PHASE_W-1:0] lo_width;
    logic [PHASE_W-1:0] hi_width;
    ctrl_t              ctrl;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_load_val;
    logic               running;
    logic               car_gate;
    logic               car_hi;

    ir_tx_regs #(
        .PHASE_W (PHASE_W),
        .TMR_W   (TMR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .lo_width     (lo_width),
        .hi_width     (hi_width),
        .ctrl         (ctrl),
        .tmr_load     (tmr_load),
        .tmr_load_val (tmr_load_val)
    );

    ir_env_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .tick_en  (tick_en),
        .count    (tmr_value),
        .running  (running)
    );

    // Purpose: run the carrier only while it is wanted on REM.
    assign car_gate = running && ctrl.out_en && !ctrl.car_off;

    ir_carrier_gen #(
        .PHASE_W (PHASE_W)
    ) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (car_gate),
        .hi_width (hi_width),
        .lo_width (lo_width),
        .car_hi   (car_hi)
    );

    ir_out_sel u_out (
        .out_en  (ctrl.out_en),
        .car_off (ctrl.car_off),
        .running (running),
        .car_hi  (car_hi),
        .rem     (rem_out),
        .led     (led_out)
    );

    // Purpose: status for a polling controller.
    assign tmr_idle = !running;

endmodule

// File: rtl/ir_tx_checker.sv
// Module: ir_tx_checker
// Property checks for ir_carrier_envelope, attached with bind.
module ir_tx_checker #(
    parameter int TMR_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             tick_en,
    input logic             rem_out,
    input logic             led_out,
    input logic             tmr_idle,
    input logic [TMR_W-1:0] tmr_value,
    input logic             out_en,
    input logic             car_off,
    input logic             car_gate,
    input logic             car_hi
);

    logic tmr_wr;
    assign tmr_wr = wr_en && (wr_sel == 2'd2);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!rem_out && !led_out && tmr_idle));

    assert_burst_starts_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(car_gate) |-> car_hi);

    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && tick_en && !tmr_idle) |=> (tmr_value == $past(tmr_value) - 1'b1));

    assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && !tick_en) |=> $stable(tmr_value));

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_idle |-> !rem_out);

    assert_plain_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && car_off) |-> (rem_out == !tmr_idle));

    assert_outputs_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!rem_out && !led_out));

    assert_led_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (led_out == !tmr_idle));

endmodule

bind ir_carrier_envelope ir_tx_checker #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .tick_en   (tick_en),
    .rem_out   (rem_out),
    .led_out   (led_out),
    .tmr_idle  (tmr_idle),
    .tmr_value (tmr_value),
    .out_en    (ctrl.out_en),
    .car_off   (ctrl.car_off),
    .car_gate  (car_gate),
    .car_hi    (car_hi)
);

// File: tb/ir_carrier_envelope_bench.sv
`timescale 1ns/1ps
module ir_carrier_envelope_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [9:0] wr_data = '0;
    logic       tick_en = 1'b0;
    logic       rem_out;
    logic       led_out;
    logic       tmr_idle;
    logic [8:0] tmr_value;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ir_carrier_envelope u_ir_carrier_envelope (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .tick_en   (tick_en),
        .rem_out   (rem_out),
        .led_out   (led_out),
        .tmr_idle  (tmr_idle),
        .tmr_value (tmr_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the capturing edge.
    task automatic wr(input logic [1:0] sel, input logic [9:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic quiesce();
        tick_en = 1'b0;
        wr(2'd2, 10'd0);
    endtask

    task automatic t_reset();
        check("R1 rem after reset", rem_out, 0);
        check("R1 led after reset", led_out, 0);
        check("R1 idle after reset", tmr_idle, 1);
        // Carrier-disable is set by reset: enabling output gives a plain level.
        wr(2'd3, 10'd1);
        wr(2'd2, 10'd20);
        for (int k = 0; k < 12; k++) begin
            check("R1 carrier off after reset (steady REM)", rem_out, 1);
            @(negedge clk);
        end
        quiesce();
    endtask

    task automatic t_carrier(input int hi, input int lo);
        wr(2'd0, 10'(lo));
        wr(2'd1, 10'(hi));
        wr(2'd3, 10'd1);
        tick_en = 1'b0;
        wr(2'd2, 10'd300);
        check("R3 first cycle high", rem_out, 1);
        for (int k = 0; k < 3 * (hi + lo + 2); k++) begin
            check("R2 R7 carrier pattern", rem_out,
                  ((k % (hi + lo + 2)) < (hi + 1)) ? 1 : 0);
            check("R10 led while running", led_out, 1);
            @(negedge clk);
        end
        quiesce();
        check("R7 rem low after stop", rem_out, 0);
        check("R10 led low after stop", led_out, 0);
    endtask

    task automatic t_midwrite();
        int exp_seq [13] = '{1,1,1,1,1,1,1,0,1,1,0,1,1};
        wr(2'd0, 10'd0);
        wr(2'd1, 10'd6);
        wr(2'd3, 10'd1);
        tick_en = 1'b0;
        wr(2'd2, 10'd400);
        for (int k = 0; k < 13; k++) begin
            check("R4 width change at boundary", rem_out, exp_seq[k]);
            if (k == 0) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 10'd1;
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
        quiesce();
    endtask

    task automatic t_timer();
        wr(2'd3, 10'd1);
        tick_en = 1'b1;
        wr(2'd2, 10'd5);
        for (int k = 0; k < 7; k++) begin
            check("R5 timer value", tmr_value, (k < 5) ? 5 - k : 0);
            check("R5 idle flag", tmr_idle, (k < 5) ? 0 : 1);
            @(negedge clk);
        end
        tick_en = 1'b0;
        wr(2'd2, 10'd9);
        repeat (4) @(negedge clk);
        check("R5 hold without tick", tmr_value, 9);
        // Reload while running, then stop with zero.
        tick_en = 1'b1;
        wr(2'd2, 10'd3);
        check("R6 loaded", tmr_value, 3);
        @(negedge clk);
        check("R6 counting", tmr_value, 2);
        wr(2'd2, 10'd10);
        check("R6 reload while running", tmr_value, 10);
        wr(2'd2, 10'd0);
        check("R6 zero write stops", tmr_idle, 1);
        quiesce();
    endtask

    task automatic t_plain();
        wr(2'd1, 10'h204);
        wr(2'd3, 10'd1);
        tick_en = 1'b1;
        wr(2'd2, 10'd4);
        for (int k = 0; k < 6; k++) begin
            check("R8 plain level", rem_out, (k < 4) ? 1 : 0);
            check("R10 led level", led_out, (k < 4) ? 1 : 0);
            @(negedge clk);
        end
        quiesce();
    endtask

    task automatic t_disabled_out();
        wr(2'd1, 10'd0);
        wr(2'd0, 10'd0);
        wr(2'd3, 10'd0);
        tick_en = 1'b0;
        wr(2'd2, 10'd50);
        for (int k = 0; k < 6; k++) begin
            check("R9 rem quiet", rem_out, 0);
            check("R9 led quiet", led_out, 0);
            @(negedge clk);
        end
        check("R9 timer still running", tmr_idle, 0);
        // Turning output on now shows the carrier at once, high first.
        wr(2'd3, 10'd1);
        check("R3 start high after enable", rem_out, 1);
        @(negedge clk);
        check("R2 one-clock low phase", rem_out, 0);
        quiesce();
    endtask

    task automatic t_midreset();
        wr(2'd3, 10'd1);
        wr(2'd1, 10'd3);
        wr(2'd2, 10'd40);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rem cleared", rem_out, 0);
        check("R1 idle after reset", tmr_idle, 1);
        check("R1 value cleared", tmr_value, 0);
        wr(2'd2, 10'd8);
        check("R1 output flag cleared", led_out, 0);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carrier(4, 2);
        t_carrier(0, 0);
        t_carrier(2, 7);
        t_carrier(255, 255);
        t_midwrite();
        t_timer();
        t_plain();
        t_disabled_out();
        t_midreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule